// File: doc/BRIEF.md
# Pipelined Burst Memory Controller

This block is a small synchronous memory with a common-I/O data path. A load cycle captures a start address. Each following cycle of the burst is either a read or a write at the current burst address. An advance input steps a 2-bit beat counter, which walks the four words of the aligned block in linear order and wraps around. Every word has four byte lanes. Each lane holds 8 data bits plus 1 parity bit.

Writes are held for one cycle in a staging register before they are committed to the array. A read in the very next cycle takes the staged lanes through a bypass, so new data is visible at once. Read data is registered and appears after the clock edge that performs the read. The core exposes a split bus (`dq_i`, `dq_o`, `dq_oe_o`), and the pad ring joins these into one shared bidirectional bus.

The output enable is a combinational gate. A write cycle always forces the bus off. After a burst stops reading, the outputs stay driven for one extra clock before they are released.

Top module: `pburst_sram`

## Requirements
- R1: A cycle with `start_i`=1 and `sel_i`=1 loads `addr_i` as the burst base and resets the beat to 0. Write controls present in that cycle write nothing.
- R2: A read edge is a clock edge in an active burst with `start_i`=0 and no write control asserted. It makes the word at the current burst address appear on `dq_o`, with `dq_oe_o`=1, right after that edge. The first read edge is the edge that follows the load.
- R3: Burst addresses keep the upper address bits of the base. The low 2 bits on beat j are (base[1:0] + j) mod 4.
- R4: With `adv_i`=0 a read or write edge leaves the burst address unchanged. With `adv_i`=1 the next edge uses the next beat.
- R5: With `wr_all_n_i`=0 in an active non-load cycle, all four lanes are written from `dq_i`, whatever `byte_gate_n_i` and `lane_wr_n_i` are.
- R6: With `wr_all_n_i`=1 and `byte_gate_n_i`=0, lane k (bits 9k+8..9k, where bit 9k+8 is parity) is written only when `lane_wr_n_i[k]`=0. All other lanes keep their contents.
- R7: With `wr_all_n_i`=1 and `byte_gate_n_i`=1 the cycle is a read. `lane_wr_n_i` is ignored and memory is unchanged.
- R8: A read at the address written in the immediately preceding cycle returns the newly written lanes. This also holds after two back-to-back partial writes.
- R9: In a write cycle `dq_oe_o` is 0, whatever `oe_n_i` is.
- R10: `oe_n_i`=1 forces `dq_oe_o` to 0 in the same cycle. `oe_n_i`=0 restores driving of the held read data.
- R11: After the last read edge, the first edge that is neither a read nor a write keeps `dq_oe_o`=1 with the same data. The second such edge releases the bus. A deselect (`start_i`=1, `sel_i`=0) ends the burst.
- R12: During and after reset the bus is not driven. No read happens until a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Address strobe: load (with sel_i) or deselect |
| sel_i | input | 1 | Chip select, sampled with start_i |
| adv_i | input | 1 | Step the burst beat after this edge |
| addr_i | input | ADDR_W | Burst start address |
| wr_all_n_i | input | 1 | Global write, active low, all lanes |
| byte_gate_n_i | input | 1 | Active low gate enabling lane writes |
| lane_wr_n_i | input | LANES | Per-lane write enables, active low |
| oe_n_i | input | 1 | Output enable, active low, combinational |
| dq_i | input | LANES*LANE_BITS | Write data from the bus |
| dq_o | output | LANES*LANE_BITS | Registered read data |
| dq_oe_o | output | 1 | Bus driver enable |

## Verification
Every address is written through global-write bursts whose load addresses fall on each of the four block offsets. Every start address is then read back as a full burst, which separates a correct linear wrap from plain incrementing, and back-to-back bursts expose the extra clock of drive. All sixteen lane masks are written to one word and read back in the next cycle. This checks the lane merge and the staging bypass together. Global write is combined with conflicting lane enables, lane enables are given without the gate, and a write is placed directly after reads with the output enabled. These cases separate the write decode priorities and the forced release of the bus during writes. Deselect followed by an advance request shows the two-step release, and it also shows that an inactive burst does not read.

// File: rtl/pburst_pkg.sv
package pburst_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE,
    CYC_LOAD,
    CYC_READ,
    CYC_WRITE
  } cyc_kind_e;
endpackage

// File: rtl/pburst_seq.sv
module pburst_seq #(
  parameter int ADDR_W = 4,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              drop_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              active_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic              active_q, active_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [ADDR_W-1:0] base_q;

  always_comb begin
    active_d = active_q;
    beat_d   = beat_q;
    if (load_i) begin
      active_d = 1'b1;
      beat_d   = '0;
    end else if (drop_i) begin
      active_d = 1'b0;
    end else if (step_i) begin
      beat_d = beat_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
    end else begin
      active_q <= active_d;
      beat_q   <= beat_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_i) base_q <= addr_i;
  end

  assign active_o = active_q;
  assign addr_o   = {base_q[ADDR_W-1:BEAT_W], base_q[BEAT_W-1:0] + beat_q};

  AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (active_o && addr_o == $past(addr_i))); // R1
  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && !drop_i) |=> (addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W]) &&
      addr_o[BEAT_W-1:0] == $past(addr_o[BEAT_W-1:0]) + 1'b1)); // R3
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !load_i) |=> $stable(addr_o)); // R4
endmodule

// File: rtl/pburst_store.sv
module pburst_store #(
  parameter int ADDR_W    = 4,
  parameter int LANES     = 4,
  parameter int LANE_BITS = 9
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [LANES-1:0]           wr_mask_i,
  input  logic [LANES*LANE_BITS-1:0] wr_data_i,
  input  logic [ADDR_W-1:0]          rd_addr_i,
  output logic [LANES*LANE_BITS-1:0] rd_data_o
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = LANES * LANE_BITS;

  logic              pend_vld_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [LANES-1:0]  pend_mask_q;
  logic [WORD_W-1:0] pend_data_q;
  logic              addr_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_vld_q <= 1'b0;
    else        pend_vld_q <= wr_en_i;
  end

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      pend_addr_q <= wr_addr_i;
      pend_mask_q <= wr_mask_i;
      pend_data_q <= wr_data_i;
    end
  end

  assign addr_hit = pend_vld_q && (pend_addr_q == rd_addr_i);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_BITS-1:0] lane_mem [DEPTH];
    logic                 commit;
    assign commit = pend_vld_q && pend_mask_q[l];

    always_ff @(posedge clk) begin
      if (commit) lane_mem[pend_addr_q] <= pend_data_q[l*LANE_BITS +: LANE_BITS];
    end

    assign rd_data_o[l*LANE_BITS +: LANE_BITS] =
      (addr_hit && pend_mask_q[l]) ? pend_data_q[l*LANE_BITS +: LANE_BITS]
                                   : lane_mem[rd_addr_i];
  end

  AST_STAGE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (pend_vld_q && pend_addr_q == $past(wr_addr_i) && pend_mask_q == $past(wr_mask_i))); // R6
  AST_BYPASS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && &wr_mask_i) |=> ((rd_addr_i != pend_addr_q) || (rd_data_o == $past(wr_data_i)))); // R8
endmodule

// File: rtl/pburst_out.sv
module pburst_out #(
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_read_i,
  input  logic              is_write_i,
  input  logic              oe_n_i,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic [WORD_W-1:0] dq_o,
  output logic              dq_oe_o
);
  logic drive_q, drive_d;
  logic linger_q, linger_d;
  logic [WORD_W-1:0] hold_q;

  always_comb begin
    if (is_read_i) begin
      drive_d  = 1'b1;
      linger_d = 1'b0;
    end else if (is_write_i) begin
      drive_d  = 1'b0;
      linger_d = 1'b0;
    end else begin
      drive_d  = drive_q & ~linger_q;
      linger_d = drive_q & ~linger_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q  <= 1'b0;
      linger_q <= 1'b0;
    end else begin
      drive_q  <= drive_d;
      linger_q <= linger_d;
    end
  end

  always_ff @(posedge clk) begin
    if (is_read_i) hold_q <= rd_data_i;
  end

  assign dq_o    = hold_q;
  assign dq_oe_o = drive_q & ~oe_n_i & ~is_write_i;

  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    is_read_i |=> (drive_q && hold_q == $past(rd_data_i))); // R2
  AST_DCD_EXTRA: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_q && !linger_q && !is_read_i && !is_write_i) |=> (drive_q && $stable(hold_q))); // R11
  AST_DCD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (linger_q && !is_read_i) |=> !drive_q); // R11
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    is_write_i |=> !drive_q); // R9
endmodule

// File: rtl/pburst_sram.sv
module pburst_sram
  import pburst_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int LANES     = 4,
  parameter int LANE_BITS = 9,
  parameter int BEAT_W    = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic                       sel_i,
  input  logic                       adv_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       wr_all_n_i,
  input  logic                       byte_gate_n_i,
  input  logic [LANES-1:0]           lane_wr_n_i,
  input  logic                       oe_n_i,
  input  logic [LANES*LANE_BITS-1:0] dq_i,
  output logic [LANES*LANE_BITS-1:0] dq_o,
  output logic                       dq_oe_o
);
  localparam int WORD_W = LANES * LANE_BITS;

  cyc_kind_e         kind;
  logic              active;
  logic [ADDR_W-1:0] cur_addr;
  logic [LANES-1:0]  wr_mask;
  logic [WORD_W-1:0] rd_word;
  logic              is_read, is_write, step;

  always_comb begin
    if (start_i)                          kind = sel_i ? CYC_LOAD : CYC_IDLE;
    else if (!active)                     kind = CYC_IDLE;
    else if (!wr_all_n_i || !byte_gate_n_i) kind = CYC_WRITE;
    else                                  kind = CYC_READ;
  end

  assign is_read  = (kind == CYC_READ);
  assign is_write = (kind == CYC_WRITE);
  assign step     = adv_i & (is_read | is_write);
  assign wr_mask  = !wr_all_n_i ? {LANES{1'b1}} : ~lane_wr_n_i;

  pburst_seq #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (kind == CYC_LOAD),
    .drop_i   (start_i & ~sel_i),
    .step_i   (step),
    .addr_i   (addr_i),
    .active_o (active),
    .addr_o   (cur_addr)
  );

  pburst_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_BITS(LANE_BITS)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (is_write),
    .wr_addr_i (cur_addr),
    .wr_mask_i (wr_mask),
    .wr_data_i (dq_i),
    .rd_addr_i (cur_addr),
    .rd_data_o (rd_word)
  );

  pburst_out #(.WORD_W(WORD_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .is_read_i  (is_read),
    .is_write_i (is_write),
    .oe_n_i     (oe_n_i),
    .rd_data_i  (rd_word),
    .dq_o       (dq_o),
    .dq_oe_o    (dq_oe_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> !dq_oe_o); // R12
  AST_LOAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !u_store.pend_vld_q); // R1
  AST_GW_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && active && !wr_all_n_i) |=> (u_store.pend_mask_q == {LANES{1'b1}})); // R5
  AST_GATE_OFF_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && active && wr_all_n_i && byte_gate_n_i) |=> !u_store.pend_vld_q); // R7
endmodule

// File: tb/pburst_sram_test.sv
module pburst_sram_test;
  localparam int PER = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, sel_i, adv_i;
  logic [3:0]  addr_i;
  logic        wr_all_n_i, byte_gate_n_i;
  logic [3:0]  lane_wr_n_i;
  logic        oe_n_i;
  logic [35:0] dq_i;
  logic [35:0] dq_o;
  logic        dq_oe_o;

  logic [35:0] refm [16];
  logic [35:0] last;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(PER/2) clk = ~clk;

  pburst_sram uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sel_i(sel_i), .adv_i(adv_i),
    .addr_i(addr_i), .wr_all_n_i(wr_all_n_i), .byte_gate_n_i(byte_gate_n_i),
    .lane_wr_n_i(lane_wr_n_i), .oe_n_i(oe_n_i), .dq_i(dq_i),
    .dq_o(dq_o), .dq_oe_o(dq_oe_o)
  );

  function automatic logic [35:0] pat(input int a, input int s);
    return {9'(a*37 + s), 9'(a*11 + 3*s + 5), 9'(a ^ (s*7)), 9'(~(a + s))};
  endfunction

  function automatic int baddr(input int b, input int j);
    return (b & ~3) | ((b + j) & 3);
  endfunction

  task automatic tick();
    @(posedge clk);
    #(PER/4);
  endtask

  task automatic idle_in();
    start_i = 0; sel_i = 0; adv_i = 0; addr_i = 0;
    wr_all_n_i = 1; byte_gate_n_i = 1; lane_wr_n_i = 4'hF; dq_i = '0;
  endtask

  task automatic load(input int a);
    idle_in(); start_i = 1; sel_i = 1; addr_i = 4'(a);
    tick();
  endtask

  task automatic ref_write(input int a, input logic [3:0] m, input logic [35:0] d);
    for (int l = 0; l < 4; l++)
      if (m[l]) refm[a][l*9 +: 9] = d[l*9 +: 9];
  endtask

  task automatic chk_on(input string req, input logic [35:0] exp);
    n_chk++;
    if (dq_oe_o !== 1'b1 || dq_o !== exp) begin
      n_bad++;
      $display("FAIL %s: oe=%b data=%h, expected oe=1 data=%h", req, dq_oe_o, dq_o, exp);
    end
  endtask

  task automatic chk_off(input string req);
    n_chk++;
    if (dq_oe_o !== 1'b0) begin
      n_bad++;
      $display("FAIL %s: oe=%b, expected oe=0", req, dq_oe_o);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; oe_n_i = 0; idle_in();
    repeat (3) tick();
    chk_off("R12 bus quiet in reset");
    rst_n = 1; adv_i = 1;
    tick();
    chk_off("R12 no read before load");

    // fill every address with global writes; load cycle carries a write that must be dropped (R1)
    for (int k = 0; k < 4; k++) begin
      idle_in(); start_i = 1; sel_i = 1; addr_i = 4'(k*5);
      wr_all_n_i = 0; dq_i = '1;
      tick();
      for (int j = 0; j < 4; j++) begin
        idle_in(); adv_i = 1; wr_all_n_i = 0; dq_i = pat(baddr(k*5, j), 0);
        tick();
        ref_write(baddr(k*5, j), 4'hF, pat(baddr(k*5, j), 0));
      end
    end

    // read every start address as a full burst (R1, R2, R3, R11)
    for (int s = 0; s < 16; s++) begin
      load(s);
      if (s > 0) chk_on("R11 drive held one edge after reads", last);
      for (int j = 0; j < 4; j++) begin
        idle_in(); adv_i = 1;
        tick();
        chk_on(j == 0 ? "R2 first beat" : "R3 burst order", refm[baddr(s, j)]);
        last = refm[baddr(s, j)];
      end
    end

    // advance held low (R4): beats read 6,6,6,7 then address is 4
    load(6);
    idle_in(); tick(); chk_on("R4 hold", refm[6]);
    idle_in(); tick(); chk_on("R4 hold", refm[6]);
    idle_in(); adv_i = 1; tick(); chk_on("R4 step", refm[6]);
    idle_in(); adv_i = 1; tick(); chk_on("R4 step", refm[7]);

    // write right after reads with output enabled (R9), then pass-through (R8)
    idle_in(); wr_all_n_i = 0; dq_i = pat(4, 1);
    #1 chk_off("R9 write cycle releases bus");
    tick(); ref_write(4, 4'hF, pat(4, 1));
    idle_in(); tick(); chk_on("R8 pass-through", refm[4]);

    // output enable (R10)
    oe_n_i = 1; #1 chk_off("R10 oe high");
    oe_n_i = 0; #1 chk_on("R10 oe low", refm[4]);

    // every lane mask at address 3 (R6, R8)
    for (int m = 0; m < 16; m++) begin
      load(3);
      idle_in(); byte_gate_n_i = 0; lane_wr_n_i = ~4'(m); dq_i = pat(3, m + 2);
      tick(); ref_write(3, 4'(m), pat(3, m + 2));
      idle_in(); tick();
      chk_on("R6 lane merge", refm[3]);
    end

    // global write overrides lane enables (R5)
    load(9);
    idle_in(); wr_all_n_i = 0; byte_gate_n_i = 0; lane_wr_n_i = 4'b1010; dq_i = pat(9, 40);
    tick(); ref_write(9, 4'hF, pat(9, 40));
    idle_in(); tick(); chk_on("R5 gw with lane enables", refm[9]);
    idle_in(); wr_all_n_i = 0; dq_i = pat(9, 41);
    tick(); ref_write(9, 4'hF, pat(9, 41));
    idle_in(); tick(); chk_on("R5 gw without gate", refm[9]);

    // two back-to-back partial writes then read (R8)
    load(12);
    idle_in(); byte_gate_n_i = 0; lane_wr_n_i = ~4'b0011; dq_i = pat(12, 50);
    tick(); ref_write(12, 4'b0011, pat(12, 50));
    idle_in(); byte_gate_n_i = 0; lane_wr_n_i = ~4'b1100; dq_i = pat(12, 51);
    tick(); ref_write(12, 4'b1100, pat(12, 51));
    idle_in(); tick(); chk_on("R8 chained partial writes", refm[12]);

    // lane enables without gate are ignored (R7)
    load(2);
    idle_in(); lane_wr_n_i = 4'h0; dq_i = pat(2, 60);
    tick(); chk_on("R7 gate high reads", refm[2]);
    idle_in(); lane_wr_n_i = 4'h0; dq_i = pat(2, 61);
    tick(); chk_on("R7 memory unchanged", refm[2]);

    // deselect: two-step release, inactive burst does not read (R11)
    idle_in(); start_i = 1; sel_i = 0;
    tick(); chk_on("R11 first edge after deselect", refm[2]);
    idle_in(); adv_i = 1;
    tick(); chk_off("R11 released on second edge");
    tick(); chk_off("R11 stays released");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule